// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts video scanlines and raises an interrupt request to the CPU once a programmed number of lines has gone by. Software writes a reload value and then clears the counter. The counter then steps once per qualifying scanline. When it counts down to zero while interrupts are allowed, the request line goes high and stays high until software disables the interrupt.

A scanline step happens in the one cycle where the dot number from the video timing equals a fixed dot. The line must be a visible line or the pre-render line, and at least one of the two rendering layers must be on. A step that finds the counter at zero loads the reload value and does not decrement. That is why a reload of N raises the request on the step N+1 steps after a clear. The video generator and the CPU's handling of the request sit outside this block.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the request line is low, the counter and the reload value are zero, and the interrupt is disabled.
- R2: A write with address bits [15:13] = 3'b110 and address bit 0 = 0 stores the 8-bit data as the reload value.
- R3: A write with address bits [15:13] = 3'b110 and address bit 0 = 1 sets the counter to zero. When this write falls in the same cycle as a step, the write wins.
- R4: A write with address bits [15:13] = 3'b111 disables the interrupt and drops the request when address bit 0 = 0, and enables the interrupt when address bit 0 = 1.
- R5: A step occurs only in a cycle where the dot number equals 260.
- R6: Lines 0 to 239 and line 261 allow a step. Lines 240 to 260 never step.
- R7: No step occurs while the background and sprite enables are both low. Either enable alone is enough.
- R8: A step that finds the counter at zero loads the reload value and requests nothing. With a reload of zero the counter stays at zero and never requests.
- R9: A step that finds the counter nonzero decrements it. If the result is zero and the interrupt is enabled, the request line is high from the next clock edge on. If the interrupt is disabled, the line stays low.
- R10: Once high, the request line stays high through further steps and through other writes until a disable write.
- R11: Writes whose address bits [15:13] are not 3'b110 or 3'b111 change neither the reload value, the counter nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| line_num | input | 9 | Current scanline number |
| dot_num | input | 9 | Current dot number within the line |
| bg_on | input | 1 | Background rendering enabled |
| spr_on | input | 1 | Sprite rendering enabled |
| irq_req | output | 1 | Interrupt request, level, active high |

## Verification
Every write and every step takes effect at the clock edge that samples it. The request line therefore changes exactly one edge after the step that counts down to zero, and one edge after a disable write. The bench applies each stimulus for a single cycle starting at a falling edge. It reads the request at the next falling edge, half a cycle after the edge where the value is due. The counter and the reload value are not visible at the ports. The bench shows them through the request line: after each write, it counts how many steps pass before the request appears.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  // Decoded write strobes, at most one set per cycle
  typedef struct packed {
    logic set_reload;
    logic clear_count;
    logic irq_off;
    logic irq_on;
  } scanirq_wr_t;

  // A line may step the counter when it is visible or the pre-render line
  function automatic logic line_eligible(input int unsigned line,
                                         input int unsigned last_visible,
                                         input int unsigned prerender);
    return (line <= last_visible) || (line == prerender);
  endfunction

  // Either rendering layer on lets the counter step
  function automatic logic render_active(input logic bg, input logic spr);
    return bg | spr;
  endfunction

endpackage

// File: rtl/scanirq_regdec.sv
module scanirq_regdec
  import scanirq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output scanirq_wr_t       wr
);

  localparam logic [2:0] COUNT_WIN = 3'b110;
  localparam logic [2:0] FLAG_WIN  = 3'b111;

  logic [2:0] win;
  logic       odd;

  assign win = cpu_addr[ADDR_W-1 -: 3];
  assign odd = cpu_addr[0];

  always_comb begin
    wr = '0;
    if (cpu_we) begin
      if (win == COUNT_WIN) begin
        wr.set_reload  = !odd;
        wr.clear_count = odd;
      end else if (win == FLAG_WIN) begin
        wr.irq_off = !odd;
        wr.irq_on  = odd;
      end
    end
  end

endmodule

// File: rtl/scanirq_qualify.sv
module scanirq_qualify
  import scanirq_pkg::*;
#(
  parameter int LINE_W       = 9,
  parameter int DOT_W        = 9,
  parameter int FIRE_DOT     = 260,
  parameter int LAST_VISIBLE = 239,
  parameter int PRERENDER    = 261
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic [DOT_W-1:0]  dot_num,
  input  logic              bg_on,
  input  logic              spr_on,
  output logic              line_tick
);

  localparam logic [DOT_W-1:0] FIRE_DOT_V = DOT_W'(FIRE_DOT);

  logic at_dot;
  logic line_ok;
  logic render_ok;

  assign at_dot    = (dot_num == FIRE_DOT_V);
  assign line_ok   = line_eligible(int'(line_num), LAST_VISIBLE, PRERENDER);
  assign render_ok = render_active(bg_on, spr_on);
  assign line_tick = at_dot && line_ok && render_ok;

endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter
  import scanirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scanirq_wr_t       wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              dec_to_zero
);

  // Counter step: zero reloads, anything else decrements
  function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] cur,
                                             input logic [DATA_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  logic [DATA_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (wr.clear_count)  count_d = '0;
    else if (line_tick)  count_d = step(count_q, reload_q);
  end

  // Event: a nonzero counter steps down to zero this cycle
  assign dec_to_zero = line_tick && !wr.clear_count &&
                       (count_q != '0) && (count_q == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q <= count_d;
      if (wr.set_reload) reload_q <= wr_data;
    end
  end

endmodule

// File: rtl/scanirq_flag.sv
module scanirq_flag
  import scanirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  scanirq_wr_t wr,
  input  logic        dec_to_zero,
  output logic        irq_en,
  output logic        irq_q
);

  logic fire;

  assign fire = dec_to_zero && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr.irq_off) begin
        irq_en <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        if (wr.irq_on) irq_en <= 1'b1;
        if (fire)      irq_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scanirq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int LINE_W       = 9,
  parameter int DOT_W        = 9,
  parameter int FIRE_DOT     = 260,
  parameter int LAST_VISIBLE = 239,
  parameter int PRERENDER    = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [LINE_W-1:0] line_num,
  input  logic [DOT_W-1:0]  dot_num,
  input  logic              bg_on,
  input  logic              spr_on,
  output logic              irq_req
);

  scanirq_wr_t       wr;
  logic              line_tick;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] reload_q;
  logic              dec_to_zero;
  logic              irq_en;

  scanirq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .wr       (wr)
  );

  scanirq_qualify #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .FIRE_DOT(FIRE_DOT),
    .LAST_VISIBLE(LAST_VISIBLE), .PRERENDER(PRERENDER)
  ) u_qual (
    .line_num  (line_num),
    .dot_num   (dot_num),
    .bg_on     (bg_on),
    .spr_on    (spr_on),
    .line_tick (line_tick)
  );

  scanirq_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr),
    .wr_data     (cpu_data),
    .line_tick   (line_tick),
    .count_q     (count_q),
    .reload_q    (reload_q),
    .dec_to_zero (dec_to_zero)
  );

  scanirq_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr),
    .dec_to_zero (dec_to_zero),
    .irq_en      (irq_en),
    .irq_q       (irq_req)
  );

endmodule

// File: rtl/scanirq_checker.sv
module scanirq_checker
  import scanirq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DOT_W    = 9,
  parameter int FIRE_DOT = 260
) (
  input logic              clk,
  input logic              rst_n,
  input scanirq_wr_t       wr,
  input logic              line_tick,
  input logic [DOT_W-1:0]  dot_num,
  input logic              bg_on,
  input logic              spr_on,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              irq_en,
  input logic              irq_req
);

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr.clear_count |=> (count_q == '0));

  assert_off_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr.irq_off |=> (!irq_req && !irq_en));

  assert_tick_dot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |-> (dot_num == DOT_W'(FIRE_DOT)));

  assert_tick_render_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |-> (bg_on || spr_on));

  assert_zero_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !wr.clear_count && count_q == '0) |=> (count_q == $past(reload_q)));

  assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(line_tick) && $past(irq_en) && count_q == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !wr.irq_off) |=> irq_req);

endmodule

bind scanline_irq_unit scanirq_checker #(
  .DATA_W(DATA_W), .DOT_W(DOT_W), .FIRE_DOT(FIRE_DOT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr        (wr),
  .line_tick (line_tick),
  .dot_num   (dot_num),
  .bg_on     (bg_on),
  .spr_on    (spr_on),
  .count_q   (count_q),
  .reload_q  (reload_q),
  .irq_en    (irq_en),
  .irq_req   (irq_req)
);

// File: tb/scanline_irq_unit_test.sv
module scanline_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [8:0]  line_num = '0;
  logic [8:0]  dot_num = '0;
  logic        bg_on = 1'b0;
  logic        spr_on = 1'b0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanline_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .line_num(line_num), .dot_num(dot_num),
    .bg_on(bg_on), .spr_on(spr_on), .irq_req(irq_req)
  );

  // Vector: kind(2) addr(16) data(8) line(9) dot(9) bg spr exp(1) req(4)
  localparam int VW = 51;
  localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_LINE = 2'd2;
  localparam int NV = 38;
  localparam logic [VW-1:0] VEC [NV] = '{
    {K_WR,   16'hE001, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // R4 enable
    {K_WR,   16'hC000, 8'd3, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd2},  // R2 reload 3
    {K_LINE, 16'h0000, 8'd0, 9'd10,  9'd260, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 0 -> 3
    {K_LINE, 16'h0000, 8'd0, 9'd11,  9'd260, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 3 -> 2
    {K_LINE, 16'h0000, 8'd0, 9'd12,  9'd259, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 wrong dot
    {K_LINE, 16'h0000, 8'd0, 9'd245, 9'd260, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 blanked line
    {K_LINE, 16'h0000, 8'd0, 9'd12,  9'd260, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 render off
    {K_LINE, 16'h0000, 8'd0, 9'd261, 9'd260, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 pre-render 2 -> 1
    {K_LINE, 16'h0000, 8'd0, 9'd0,   9'd260, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 1 -> 0 fires
    {K_IDLE, 16'h0000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b1, 4'd10}, // R10 held
    {K_LINE, 16'h0000, 8'd0, 9'd1,   9'd260, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 0 -> 3, held
    {K_WR,   16'hE000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // R4 disable drops
    {K_LINE, 16'h0000, 8'd0, 9'd2,   9'd260, 1'b1, 1'b1, 1'b0, 4'd9},  // 3 -> 2
    {K_LINE, 16'h0000, 8'd0, 9'd3,   9'd260, 1'b1, 1'b1, 1'b0, 4'd9},  // 2 -> 1
    {K_LINE, 16'h0000, 8'd0, 9'd4,   9'd260, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 1 -> 0 disabled
    {K_WR,   16'hE001, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // enable
    {K_WR,   16'hC000, 8'd2, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd2},  // R2 reload 2
    {K_LINE, 16'h0000, 8'd0, 9'd5,   9'd260, 1'b1, 1'b0, 1'b0, 4'd8},  // 0 -> 2
    {K_WR,   16'hC001, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd3},  // R3 clear
    {K_LINE, 16'h0000, 8'd0, 9'd6,   9'd260, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 0 -> 2
    {K_LINE, 16'h0000, 8'd0, 9'd7,   9'd260, 1'b1, 1'b0, 1'b0, 4'd3},  // 2 -> 1
    {K_LINE, 16'h0000, 8'd0, 9'd8,   9'd260, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 1 -> 0 fires
    {K_WR,   16'hA000, 8'd5, 9'd0,   9'd0,   1'b0, 1'b0, 1'b1, 4'd11}, // R11 ignored
    {K_WR,   16'h8000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b1, 4'd11}, // R11 ignored
    {K_WR,   16'hE000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // disable
    {K_WR,   16'hE001, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // enable
    {K_WR,   16'h8001, 8'd7, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd11}, // R11 ignored
    {K_LINE, 16'h0000, 8'd0, 9'd9,   9'd260, 1'b1, 1'b0, 1'b0, 4'd11}, // 0 -> 2 (not 5/7)
    {K_LINE, 16'h0000, 8'd0, 9'd10,  9'd260, 1'b1, 1'b0, 1'b0, 4'd11}, // 2 -> 1
    {K_LINE, 16'h0000, 8'd0, 9'd11,  9'd260, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 1 -> 0 fires
    {K_WR,   16'hE000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // disable
    {K_WR,   16'hC000, 8'd1, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd2},  // reload 1
    {K_LINE, 16'h0000, 8'd0, 9'd239, 9'd260, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 last visible 0 -> 1
    {K_LINE, 16'h0000, 8'd0, 9'd240, 9'd260, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 240 blanked
    {K_LINE, 16'h0000, 8'd0, 9'd260, 9'd260, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 260 blanked
    {K_WR,   16'hE001, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4},  // enable
    {K_LINE, 16'h0000, 8'd0, 9'd261, 9'd260, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 1 -> 0 fires
    {K_WR,   16'hE000, 8'd0, 9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 4'd4}   // disable
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL R%0d %s: irq_req actual %0b expected %0b", req, what, irq_req, exp);
    end
  endtask

  // Drive one cycle of stimulus from a falling edge; sample at the next falling edge
  task automatic apply(input logic [1:0] kind, input logic [15:0] a, input logic [7:0] d,
                       input logic [8:0] ln, input logic [8:0] dt, input logic b, input logic s);
    cpu_we   = (kind == K_WR);
    cpu_addr = a;
    cpu_data = d;
    line_num = ln;
    dot_num  = (kind == K_LINE) ? dt : 9'd0;
    bg_on    = b;
    spr_on   = s;
    @(negedge clk);
    cpu_we  = 1'b0;
    dot_num = 9'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1, "R1 request low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1, "R1 request low after reset");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[50:49], v[48:33], v[32:25], v[24:16], v[15:7], v[6], v[5]);
      check(v[4], int'(v[3:0]), $sformatf("vector %0d", i));
    end

    // R1 R8: reset state has reload zero and counter zero; enabled steps never fire
    apply(K_WR, 16'hE001, 8'd0, 9'd0, 9'd0, 1'b0, 1'b0);
    apply(K_WR, 16'hC000, 8'd1, 9'd0, 9'd0, 1'b0, 1'b0);
    apply(K_LINE, 16'h0, 8'd0, 9'd20, 9'd260, 1'b1, 1'b1);
    apply(K_LINE, 16'h0, 8'd0, 9'd21, 9'd260, 1'b1, 1'b1);
    check(1'b1, 10, "request before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, 1, "R1 reset drops request");
    rst_n = 1'b1;
    apply(K_WR, 16'hE001, 8'd0, 9'd0, 9'd0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      apply(K_LINE, 16'h0, 8'd0, 9'(30 + k), 9'd260, 1'b1, 1'b1);
      check(1'b0, 8, "R8 zero reload never fires");
    end

    // R3: clear in the same cycle as a step wins over the step
    apply(K_WR, 16'hC000, 8'd1, 9'd0, 9'd0, 1'b0, 1'b0);
    apply(K_LINE, 16'h0, 8'd0, 9'd40, 9'd260, 1'b1, 1'b1);   // 0 -> 1
    cpu_we = 1'b1; cpu_addr = 16'hC001; line_num = 9'd41; dot_num = 9'd260;
    bg_on = 1'b1; spr_on = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; dot_num = 9'd0;
    check(1'b0, 3, "R3 clear beats step");
    apply(K_LINE, 16'h0, 8'd0, 9'd42, 9'd260, 1'b1, 1'b1);   // 0 -> 1
    check(1'b0, 3, "R3 counter was zero after clear");
    apply(K_LINE, 16'h0, 8'd0, 9'd43, 9'd260, 1'b1, 1'b1);   // 1 -> 0
    check(1'b1, 3, "R3 fires after reload");

    finish_run();
  end

endmodule